// File: doc/BRIEF.md
# Fold Boundary Code Correction Stage

This stage repairs the fine code of a two-path (coarse plus fine) folding converter when the two paths disagree about which side of a fold boundary the sample fell on. The paths settle at slightly different instants. Near a boundary, the low bits of the fine code can therefore land on the wrong side while the coarse code is already correct, which gives a code a few steps away from the true value.

Each clock, the stage captures a coarse code, a fine code and one fine boundary comparator bit into a sample register. From that one registered sample it does three things. It picks a replacement for the low field of the fine code: all ones ("up") or all zeros ("down"), chosen by one bit of the fine code. It forms a single XOR between a chosen coarse bit and the comparator bit. It then drives out a code in which the low field is swapped for the replacement only when that XOR is 1. The result is registered. The coarse code and the upper fine bits travel through untouched.

Top module: `fold_edge_corrector`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous), coarse_o, fine_o and fixed_o are all zero.
- R2: The outputs that follow a rising edge describe the input sample that was captured on the rising edge just before it. The total latency is two clock edges.
- R3: The disagreement test is coarse bit 2 XOR fcmp_i. A substitution happens if and only if this XOR is 1.
- R4: When a substitution happens and fine bit 1 of the sample is 1 (up), fine_o[1:0] is 2'b11.
- R5: When a substitution happens and fine bit 1 of the sample is 0 (down), fine_o[1:0] is 2'b00.
- R6: When the XOR is 0, fine_o equals the sampled fine code bit for bit.
- R7: fine_o[4:2] always equals the sampled fine bits [4:2], and coarse_o always equals the sampled coarse code.
- R8: fixed_o is 1 exactly for output codes where a substitution was applied.
- R9: A disagreeing sample with fine code 5'b01001 is output as 5'b01000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coarse_i | input | 3 | Coarse binary code |
| fine_i | input | 5 | Fine binary code; the low field is bits [1:0] |
| fcmp_i | input | 1 | Fine boundary comparator output |
| coarse_o | output | 3 | Coarse code, delayed |
| fine_o | output | 5 | Fine code after correction |
| fixed_o | output | 1 | Set when the low field was replaced |

## Verification
The bench covers both outcomes of the XOR, with the comparator and the coarse bit each at 0 and at 1. This exposes a design that substitutes on agreement or tests the wrong coarse bit. It places the direction bit at both values so that swapped up and down fills show up. It checks that the upper fine bits and the whole coarse code stay constant across substitutions, which catches a mask that spills past the low field. It also drives the 01001 boundary pattern and uses long random runs to confirm the two-edge delay, so that a missing or extra pipeline register surfaces as misaligned codes.

// File: rtl/fold_edge_pkg.sv
package fold_edge_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } fill_dir_e;

  function automatic fill_dir_e dir_from_bit(input logic b);
    return b ? DIR_UP : DIR_DOWN;
  endfunction

  function automatic logic disagree(input logic coarse_bit, input logic cmp_bit);
    return coarse_bit ^ cmp_bit;
  endfunction
endpackage

// File: rtl/fold_edge_sample.sv
module fold_edge_sample #(
  parameter int CW = 3,
  parameter int FW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] coarse_d,
  input  logic [FW-1:0] fine_d,
  input  logic          cmp_d,
  output logic [CW-1:0] coarse_q,
  output logic [FW-1:0] fine_q,
  output logic          cmp_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coarse_q <= '0;
      fine_q   <= '0;
      cmp_q    <= 1'b0;
    end else begin
      coarse_q <= coarse_d;
      fine_q   <= fine_d;
      cmp_q    <= cmp_d;
    end
  end
endmodule

// File: rtl/fold_edge_decide.sv
module fold_edge_decide
  import fold_edge_pkg::*;
#(
  parameter int CW      = 3,
  parameter int FW      = 5,
  parameter int LSBW    = 2,
  parameter int DIR_BIT = 1,
  parameter int CSEL    = 2
) (
  input  logic [CW-1:0]   coarse_s,
  input  logic [FW-1:0]   fine_s,
  input  logic            cmp_s,
  output logic            mismatch,
  output fill_dir_e       dir,
  output logic [LSBW-1:0] repl_field
);
  function automatic logic [LSBW-1:0] fill_of(input fill_dir_e d);
    return (d == DIR_UP) ? {LSBW{1'b1}} : {LSBW{1'b0}};
  endfunction

  always_comb begin
    dir        = dir_from_bit(fine_s[DIR_BIT]);
    repl_field = fill_of(dir);
    mismatch   = disagree(coarse_s[CSEL], cmp_s);
  end
endmodule

// File: rtl/fold_edge_merge.sv
module fold_edge_merge #(
  parameter int CW   = 3,
  parameter int FW   = 5,
  parameter int LSBW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CW-1:0]   coarse_s,
  input  logic [FW-1:0]   fine_s,
  input  logic            mismatch,
  input  logic [LSBW-1:0] repl_field,
  output logic [CW-1:0]   coarse_o,
  output logic [FW-1:0]   fine_o,
  output logic            fixed_o
);
  localparam int UPW = FW - LSBW;

  function automatic logic [FW-1:0] splice(input logic [FW-1:0] f,
                                           input logic [LSBW-1:0] low,
                                           input logic take);
    logic [FW-1:0] r;
    r = f;
    if (take) r[LSBW-1:0] = low;
    return r;
  endfunction

  logic [FW-1:0] fine_next;
  logic [UPW-1:0] upper_keep;

  always_comb begin
    upper_keep = fine_s[FW-1:LSBW];
    fine_next  = splice(fine_s, repl_field, mismatch);
    fine_next[FW-1:LSBW] = upper_keep;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coarse_o <= '0;
      fine_o   <= '0;
      fixed_o  <= 1'b0;
    end else begin
      coarse_o <= coarse_s;
      fine_o   <= fine_next;
      fixed_o  <= mismatch;
    end
  end
endmodule

// File: rtl/fold_edge_corrector.sv
module fold_edge_corrector
  import fold_edge_pkg::*;
#(
  parameter int CW      = 3,
  parameter int FW      = 5,
  parameter int LSBW    = 2,
  parameter int DIR_BIT = 1,
  parameter int CSEL    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] coarse_i,
  input  logic [FW-1:0] fine_i,
  input  logic          fcmp_i,
  output logic [CW-1:0] coarse_o,
  output logic [FW-1:0] fine_o,
  output logic          fixed_o
);
  logic [CW-1:0]   s_coarse;
  logic [FW-1:0]   s_fine;
  logic            s_cmp;
  logic            ev_mismatch;
  fill_dir_e       ev_dir;
  logic [LSBW-1:0] ev_repl;

  fold_edge_sample #(.CW(CW), .FW(FW)) u_sample (
    .clk(clk), .rst_n(rst_n),
    .coarse_d(coarse_i), .fine_d(fine_i), .cmp_d(fcmp_i),
    .coarse_q(s_coarse), .fine_q(s_fine), .cmp_q(s_cmp)
  );

  fold_edge_decide #(.CW(CW), .FW(FW), .LSBW(LSBW), .DIR_BIT(DIR_BIT), .CSEL(CSEL)) u_decide (
    .coarse_s(s_coarse), .fine_s(s_fine), .cmp_s(s_cmp),
    .mismatch(ev_mismatch), .dir(ev_dir), .repl_field(ev_repl)
  );

  fold_edge_merge #(.CW(CW), .FW(FW), .LSBW(LSBW)) u_merge (
    .clk(clk), .rst_n(rst_n),
    .coarse_s(s_coarse), .fine_s(s_fine),
    .mismatch(ev_mismatch), .repl_field(ev_repl),
    .coarse_o(coarse_o), .fine_o(fine_o), .fixed_o(fixed_o)
  );
endmodule

// File: rtl/fold_edge_corrector_chk.sv
module fold_edge_corrector_chk #(
  parameter int CW      = 3,
  parameter int FW      = 5,
  parameter int LSBW    = 2,
  parameter int DIR_BIT = 1,
  parameter int CSEL    = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] coarse_i,
  input logic [FW-1:0] fine_i,
  input logic [CW-1:0] s_coarse,
  input logic [FW-1:0] s_fine,
  input logic          s_cmp,
  input logic [CW-1:0] coarse_o,
  input logic [FW-1:0] fine_o,
  input logic          fixed_o
);
  // R2: the sample register holds the previous cycle's inputs
  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (s_fine == $past(fine_i)) && (s_coarse == $past(coarse_i)));

  // R3, R4, R5: disagreement forces the low field from the direction bit
  a_r4_fill_on_disagree: assert property (@(posedge clk) disable iff (!rst_n)
    (s_coarse[CSEL] != s_cmp) |=>
      fine_o[LSBW-1:0] == {LSBW{$past(s_fine[DIR_BIT])}});

  // R6: agreement leaves the fine code untouched
  a_r6_pass_on_agree: assert property (@(posedge clk) disable iff (!rst_n)
    (s_coarse[CSEL] == s_cmp) |=> fine_o == $past(s_fine));

  // R7: upper fine bits and coarse code are never altered
  a_r7_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (fine_o[FW-1:LSBW] == $past(s_fine[FW-1:LSBW])) &&
             (coarse_o == $past(s_coarse)));

  // R8: the flag follows the disagreement of the sample
  a_r8_flag: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> fixed_o == $past(s_coarse[CSEL] ^ s_cmp));

  // R1: reset clears the outputs
  always_comb begin
    if (!rst_n) begin
      a_r1_reset_clear: assert (coarse_o == '0 && fine_o == '0 && fixed_o == 1'b0);
    end
  end
endmodule

bind fold_edge_corrector fold_edge_corrector_chk #(
  .CW(CW), .FW(FW), .LSBW(LSBW), .DIR_BIT(DIR_BIT), .CSEL(CSEL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .coarse_i(coarse_i), .fine_i(fine_i),
  .s_coarse(s_coarse), .s_fine(s_fine), .s_cmp(s_cmp),
  .coarse_o(coarse_o), .fine_o(fine_o), .fixed_o(fixed_o)
);

// File: tb/sim_fold_edge_corrector.sv
module sim_fold_edge_corrector;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] coarse_i = '0;
  logic [4:0] fine_i = '0;
  logic       fcmp_i = 1'b0;
  logic [2:0] coarse_o;
  logic [4:0] fine_o;
  logic       fixed_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fold_edge_corrector u0 (
    .clk(clk), .rst_n(rst_n), .coarse_i(coarse_i), .fine_i(fine_i),
    .fcmp_i(fcmp_i), .coarse_o(coarse_o), .fine_o(fine_o), .fixed_o(fixed_o)
  );

  function automatic bit want_fix(input logic [2:0] c, input logic m);
    return (c[2] != m);
  endfunction

  function automatic logic [4:0] want_fine(input logic [2:0] c, input logic [4:0] f, input logic m);
    if (!want_fix(c, m)) return f;
    return f[1] ? {f[4:2], 2'b11} : {f[4:2], 2'b00};
  endfunction

  logic [2:0] hc [0:1];
  logic [4:0] hf [0:1];
  logic       hm [0:1];

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Drive on the falling edge; compare against the sample driven two falling edges earlier.
  task automatic step(input logic [2:0] c, input logic [4:0] f, input logic m, input string req);
    logic [4:0] ef;
    @(negedge clk);
    ef = want_fine(hc[1], hf[1], hm[1]);
    check(req, {coarse_o, fine_o, fixed_o}, {hc[1], ef, want_fix(hc[1], hm[1])});
    hc[1] = hc[0]; hf[1] = hf[0]; hm[1] = hm[0];
    hc[0] = c;     hf[0] = f;     hm[0] = m;
    coarse_i = c; fine_i = f; fcmp_i = m;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 2; i++) begin hc[i] = '0; hf[i] = '0; hm[i] = 1'b0; end
    coarse_i = 3'b101; fine_i = 5'b11011; fcmp_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", {coarse_o, fine_o, fixed_o}, 9'd0);
    coarse_i = '0; fine_i = '0; fcmp_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    // R9 boundary pattern: coarse bit 2 set, comparator low -> 01001 becomes 01000
    step(3'b100, 5'b01001, 1'b0, "R9");
    step(3'b000, 5'b01001, 1'b0, "R6");
    step(3'b000, 5'b10110, 1'b1, "R4");
    step(3'b111, 5'b10110, 1'b1, "R3");
    step(3'b011, 5'b11101, 1'b1, "R5");
    step(3'b100, 5'b00010, 1'b0, "R4");
    step(3'b010, 5'b11111, 1'b0, "R6");
    step(3'b000, 5'b00000, 1'b1, "R8");
    for (int i = 0; i < 300; i++) begin
      step($urandom_range(7, 0), $urandom_range(31, 0), $urandom_range(1, 0), "R2/R7 random");
    end
    step(3'b000, 5'b00000, 1'b0, "R2");
    step(3'b000, 5'b00000, 1'b0, "R7");
    step(3'b000, 5'b00000, 1'b0, "R2");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule